// File: doc/BRIEF.md
# CAN FD Receive Ring Unpacker

This block empties a circular receive area in memory that a CAN FD controller fills with 16-byte slots. Each message starts with an 8-byte header. Its payload follows directly and may take up several slots. On a start pulse the block samples the read offset, the write offset and the ring size, all in bytes. It then fetches headers and payload words through a 64-bit read port and presents every message as a sequence of 64-bit beats on a valid/ready stream. Every beat carries the decoded header fields.

A batch ends when the requested number of messages has been delivered or when the slots between the two offsets are used up. At that point the block checks whether the controller is still running. If it is, the block writes back the advanced read offset and re-enables reception. If it is not, it raises a not-started error instead. The error flags from the most recent header (overrun, bus-off and error-passive) are kept as status outputs.

Memory layout: the 64-bit word at byte offset A holds header word 0 in bits 31:0 and header word 1 in bits 63:32. The read port returns data one cycle after a request.

Top module: `can_rx_unpack`

## Requirements
- R1: When the sampled read offset equals the sampled write offset, a batch produces no beats and, if the controller is running, writes back the unchanged read offset.
- R2: Header word 0 bit 31 gives the extended flag and bit 30 gives the RTR flag. An extended identifier is bits 29:0. A standard identifier is bits 29:18, delivered right-aligned with the upper bits zero.
- R3: Header word 1 bits 31:28 hold the DLC and bits 27:25 hold the option field, where option bit 0 (word 1 bit 25) marks an FD frame. For FD frames, DLC 0 to 8 gives that many bytes and DLC 9 to 15 gives 12, 16, 20, 24, 32, 48 or 64 bytes. For classic frames the length is the DLC clamped to 8.
- R4: A message of length L is delivered as ceil(L/8) beats, with the last one flagged. A zero-length message is a single flagged beat with all-zero data.
- R5: Payload words are read starting 8 bytes after the header. Each word address that reaches the ring size wraps to offset 0.
- R6: After each message the read offset advances by (1 + ((L+7)>>4)) x 16 bytes, modulo the ring size.
- R7: A batch stops after the requested message count, or once the consumed slots reach the number of slots available at start, whichever comes first.
- R8: At the end of a batch, done pulses for one cycle. If the controller-running input is high, the new read offset is written back together with a receive-enable pulse. Otherwise only the not-started error pulses.
- R9: Header word 1 bits 2, 1 and 0 (memory word bits 34, 33 and 32) give overrun, bus-off and error-passive. The status outputs hold the values from the most recent header.
- R10: While a beat is valid and not accepted, it and its fields stay unchanged. After reset there is no valid beat, no request, no done and the status is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a batch (accepted when idle) |
| max_msgs_i | input | CW | Maximum messages in the batch |
| started_i | input | 1 | Controller is in running state |
| rd_ptr_i | input | AW | Read byte offset |
| wr_ptr_i | input | AW | Write byte offset |
| size_i | input | AW | Ring size in bytes |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Byte offset of the requested 64-bit word |
| mem_rdata_i | input | 64 | Read data, one cycle after request |
| msg_valid_o | output | 1 | Beat valid |
| msg_ready_i | input | 1 | Beat accepted |
| msg_ext_o | output | 1 | Extended identifier flag |
| msg_rtr_o | output | 1 | Remote request flag |
| msg_id_o | output | 30 | Identifier |
| msg_opts_o | output | 3 | Option field, bit 0 = FD frame |
| msg_len_o | output | 7 | Payload length in bytes |
| msg_data_o | output | 64 | Payload word |
| msg_last_o | output | 1 | Last beat of the message |
| stat_overrun_o | output | 1 | Overrun flag of last header |
| stat_busoff_o | output | 1 | Bus-off flag of last header |
| stat_errpass_o | output | 1 | Error-passive flag of last header |
| done_o | output | 1 | Batch finished |
| rd_ptr_we_o | output | 1 | Write back the read offset |
| rd_ptr_wdata_o | output | AW | New read offset |
| rx_enable_o | output | 1 | Re-enable reception |
| not_started_o | output | 1 | Batch ended with the controller stopped |

## Verification
The batch patterns are chosen so that each one separates a different part of the decoder.

- Classic frames with standard and extended identifiers, zero length and an over-range DLC separate the identifier alignment from the classic clamp.
- FD frames of 12 and 32 bytes separate the DLC table from the slot formula.
- A 64-byte FD frame placed near the ring end shows that payload wrapping and offset wrapping happen independently.
- Limited message counts, an empty ring and a stopped controller show the two stop conditions and both batch endings.
- Irregular ready stalls throughout check that beats are held while stalled.

// File: rtl/can_rx_pkg.sv
// Shared types and the DLC-to-length mapping for the receive ring unpacker.
// Assumes: option field bit 0 marks an FD frame.
package can_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HREQ, ST_HWAIT, ST_DREQ, ST_DWAIT, ST_OUT, ST_FIN
    } rx_state_e;

    typedef struct packed {
        logic        ext;
        logic        rtr;
        logic [29:0] id;
        logic [2:0]  opts;
        logic [6:0]  len;
    } rx_hdr_t;

    localparam int FD_OPT_BIT = 0;

    // Byte length for a DLC; classic frames clamp to 8.
    function automatic logic [6:0] dlc_to_len(input logic [3:0] dlc, input logic fd);
        if (dlc <= 4'd8)  return {3'b000, dlc};
        if (!fd)          return 7'd8;
        case (dlc)
            4'd9:    return 7'd12;
            4'd10:   return 7'd16;
            4'd11:   return 7'd20;
            4'd12:   return 7'd24;
            4'd13:   return 7'd32;
            4'd14:   return 7'd48;
            default: return 7'd64;
        endcase
    endfunction

endpackage

// File: rtl/can_rx_hdr_decode.sv
// Combinational decode of one 64-bit header word into message fields,
// beat count, slot count and status flags.
// Assumes: word 0 in bits 31:0, word 1 in bits 63:32.
module can_rx_hdr_decode
    import can_rx_pkg::*;
(
    input  logic [63:0] word_i,
    output rx_hdr_t     hdr_o,
    output logic [3:0]  beats_o,
    output logic [2:0]  slots_o,
    output logic [2:0]  flags_o
);
    logic [31:0] w0, w1;
    logic [7:0]  len_r7;
    logic        unused_bits;

    // Split header words and derive fields.
    always_comb begin
        w0           = word_i[31:0];
        w1           = word_i[63:32];
        hdr_o.ext    = w0[31];
        hdr_o.rtr    = w0[30];
        hdr_o.id     = w0[31] ? w0[29:0] : {18'd0, w0[29:18]};
        hdr_o.opts   = w1[27:25];
        hdr_o.len    = dlc_to_len(w1[31:28], w1[25 + FD_OPT_BIT]);
        len_r7       = {1'b0, hdr_o.len} + 8'd7;
        beats_o      = len_r7[6:3];
        slots_o      = 3'd1 + {1'b0, len_r7[5:4]} + {2'b00, len_r7[6]} * 3'd4;
        flags_o      = w1[2:0];
    end

    assign unused_bits = ^{w1[24:3], len_r7[7]};

endmodule

// File: rtl/can_rx_ring_step.sv
// Adds an increment to a ring byte offset and wraps once at the ring size.
// Assumes: base < size and increment <= size.
module can_rx_ring_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] inc_i,
    input  logic [AW-1:0] size_i,
    output logic [AW-1:0] next_o
);
    logic [AW:0] sum, wrapped;

    // Single conditional subtract keeps the offset inside the ring.
    always_comb begin
        sum     = {1'b0, base_i} + {1'b0, inc_i};
        wrapped = sum - {1'b0, size_i};
        next_o  = (sum >= {1'b0, size_i}) ? wrapped[AW-1:0] : sum[AW-1:0];
    end

endmodule

// File: rtl/can_rx_unpack.sv
// Drains a circular ring of 16-byte receive slots into a valid/ready beat
// stream, then writes back the read offset when the controller still runs.
// Assumes: ring size is a multiple of 16 and larger than 80 bytes, inputs
// stay stable during a batch, read data arrives one cycle after request.
module can_rx_unpack
    import can_rx_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] max_msgs_i,
    input  logic          started_i,
    input  logic [AW-1:0] rd_ptr_i,
    input  logic [AW-1:0] wr_ptr_i,
    input  logic [AW-1:0] size_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [63:0]   mem_rdata_i,
    output logic          msg_valid_o,
    input  logic          msg_ready_i,
    output logic          msg_ext_o,
    output logic          msg_rtr_o,
    output logic [29:0]   msg_id_o,
    output logic [2:0]    msg_opts_o,
    output logic [6:0]    msg_len_o,
    output logic [63:0]   msg_data_o,
    output logic          msg_last_o,
    output logic          stat_overrun_o,
    output logic          stat_busoff_o,
    output logic          stat_errpass_o,
    output logic          done_o,
    output logic          rd_ptr_we_o,
    output logic [AW-1:0] rd_ptr_wdata_o,
    output logic          rx_enable_o,
    output logic          not_started_o
);
    localparam int SLOT_SHIFT = 4;
    localparam logic [AW-1:0] WORD_BYTES = AW'(8);

    rx_state_e     st;
    logic [AW-1:0] cur, size_q, avail_q, used, daddr;
    logic [CW-1:0] cnt, max_q;
    rx_hdr_t       hdr_q, hdr_d;
    logic [3:0]    beats_d, beats_left;
    logic [2:0]    slots_d, slots_q, flags_d, stat_q;
    logic [63:0]   data_q;
    logic          last_q;
    logic [AW-1:0] cur_next, dfirst, dnext, diff, slot_bytes;

    can_rx_hdr_decode u_dec (
        .word_i (mem_rdata_i),
        .hdr_o  (hdr_d),
        .beats_o(beats_d),
        .slots_o(slots_d),
        .flags_o(flags_d)
    );

    assign slot_bytes = AW'(slots_q) << SLOT_SHIFT;

    can_rx_ring_step #(.AW(AW)) u_adv (
        .base_i(cur), .inc_i(slot_bytes), .size_i(size_q), .next_o(cur_next));
    can_rx_ring_step #(.AW(AW)) u_first (
        .base_i(cur), .inc_i(WORD_BYTES), .size_i(size_q), .next_o(dfirst));
    can_rx_ring_step #(.AW(AW)) u_word (
        .base_i(daddr), .inc_i(WORD_BYTES), .size_i(size_q), .next_o(dnext));

    // Bytes between read and write offsets at batch start.
    always_comb begin
        if (wr_ptr_i >= rd_ptr_i) diff = wr_ptr_i - rd_ptr_i;
        else                      diff = wr_ptr_i + size_i - rd_ptr_i;
    end

    // Batch sequencer: header fetch, payload fetch, output hold, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cur        <= '0;
            size_q     <= '0;
            avail_q    <= '0;
            used       <= '0;
            daddr      <= '0;
            cnt        <= '0;
            max_q      <= '0;
            hdr_q      <= '0;
            beats_left <= '0;
            slots_q    <= '0;
            stat_q     <= '0;
            data_q     <= '0;
            last_q     <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start_i) begin
                    cur     <= rd_ptr_i;
                    size_q  <= size_i;
                    avail_q <= diff >> SLOT_SHIFT;
                    max_q   <= max_msgs_i;
                    used    <= '0;
                    cnt     <= '0;
                    st      <= ST_HREQ;
                end
                ST_HREQ: st <= (cnt < max_q && used < avail_q) ? ST_HWAIT : ST_FIN;
                ST_HWAIT: begin
                    hdr_q   <= hdr_d;
                    stat_q  <= flags_d;
                    slots_q <= slots_d;
                    daddr   <= dfirst;
                    if (beats_d == 4'd0) begin
                        data_q <= '0;
                        last_q <= 1'b1;
                        st     <= ST_OUT;
                    end else begin
                        beats_left <= beats_d;
                        st         <= ST_DREQ;
                    end
                end
                ST_DREQ: st <= ST_DWAIT;
                ST_DWAIT: begin
                    data_q     <= mem_rdata_i;
                    last_q     <= (beats_left == 4'd1);
                    beats_left <= beats_left - 4'd1;
                    daddr      <= dnext;
                    st         <= ST_OUT;
                end
                ST_OUT: if (msg_ready_i) begin
                    if (last_q) begin
                        cur  <= cur_next;
                        used <= used + AW'(slots_q);
                        cnt  <= cnt + CW'(1);
                        st   <= ST_HREQ;
                    end else begin
                        st <= ST_DREQ;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Memory request decode.
    always_comb begin
        mem_req_o  = 1'b0;
        mem_addr_o = daddr;
        if (st == ST_HREQ && cnt < max_q && used < avail_q) begin
            mem_req_o  = 1'b1;
            mem_addr_o = cur;
        end else if (st == ST_DREQ) begin
            mem_req_o = 1'b1;
        end
    end

    // Output stream and batch completion.
    always_comb begin
        msg_valid_o    = (st == ST_OUT);
        msg_ext_o      = hdr_q.ext;
        msg_rtr_o      = hdr_q.rtr;
        msg_id_o       = hdr_q.id;
        msg_opts_o     = hdr_q.opts;
        msg_len_o      = hdr_q.len;
        msg_data_o     = data_q;
        msg_last_o     = last_q;
        stat_overrun_o = stat_q[2];
        stat_busoff_o  = stat_q[1];
        stat_errpass_o = stat_q[0];
        done_o         = (st == ST_FIN);
        rd_ptr_we_o    = done_o && started_i;
        rx_enable_o    = done_o && started_i;
        not_started_o  = done_o && !started_i;
        rd_ptr_wdata_o = cur;
    end

endmodule

// File: rtl/can_rx_unpack_chk.sv
// Property checker for the receive ring unpacker, attached by bind.
module can_rx_unpack_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          started_i,
    input logic [AW-1:0] size_i,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          msg_valid_o,
    input logic          msg_ready_i,
    input logic          msg_ext_o,
    input logic [29:0]   msg_id_o,
    input logic [2:0]    msg_opts_o,
    input logic [6:0]    msg_len_o,
    input logic [63:0]   msg_data_o,
    input logic          msg_last_o,
    input logic          done_o,
    input logic          rd_ptr_we_o,
    input logic [AW-1:0] rd_ptr_wdata_o,
    input logic          rx_enable_o,
    input logic          not_started_o
);
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_data_o)
            && $stable(msg_len_o) && $stable(msg_last_o) && $stable(msg_id_o)); // R10
    AST_STD_ID_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o && !msg_ext_o |-> msg_id_o[29:12] == 18'd0); // R2
    AST_CLASSIC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o && !msg_opts_o[0] |-> msg_len_o <= 7'd8); // R3
    AST_MEM_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o < size_i); // R5
    AST_WB_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_we_o |-> rd_ptr_wdata_o < size_i); // R6
    AST_NO_BEAT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !msg_valid_o && !mem_req_o); // R7
    AST_WB_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_we_o || rx_enable_o |-> started_i && !not_started_o); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
endmodule

bind can_rx_unpack can_rx_unpack_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .started_i(started_i), .size_i(size_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
    .msg_ext_o(msg_ext_o), .msg_id_o(msg_id_o), .msg_opts_o(msg_opts_o),
    .msg_len_o(msg_len_o), .msg_data_o(msg_data_o), .msg_last_o(msg_last_o),
    .done_o(done_o), .rd_ptr_we_o(rd_ptr_we_o), .rd_ptr_wdata_o(rd_ptr_wdata_o),
    .rx_enable_o(rx_enable_o), .not_started_o(not_started_o)
);

// File: tb/tb_can_rx_unpack.sv
`timescale 1ns/1ps
// Scoreboard bench: put_msg fills the ring model and queues expected beats;
// the monitor pops and compares every accepted beat.
module tb_can_rx_unpack;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int RING = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] max_msgs_i = '0;
    logic          started_i = 1'b1;
    logic [AW-1:0] rd_ptr_i = '0, wr_ptr_i = '0;
    logic [AW-1:0] size_i = AW'(RING);
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic [63:0]   mem_rdata_i = '0;
    logic          msg_valid_o, msg_ready_i = 1'b0;
    logic          msg_ext_o, msg_rtr_o, msg_last_o;
    logic [29:0]   msg_id_o;
    logic [2:0]    msg_opts_o;
    logic [6:0]    msg_len_o;
    logic [63:0]   msg_data_o;
    logic          stat_overrun_o, stat_busoff_o, stat_errpass_o;
    logic          done_o, rd_ptr_we_o, rx_enable_o, not_started_o;
    logic [AW-1:0] rd_ptr_wdata_o;

    can_rx_unpack #(.AW(AW), .CW(CW)) dut (.*);

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic        ext;
        logic        rtr;
        logic [29:0] id;
        logic [2:0]  opts;
        logic [6:0]  len;
        logic [63:0] data;
        logic        last;
    } beat_t;

    beat_t       expq[$];
    logic [63:0] mem [0:RING/8-1];
    int          n_tests = 0, n_fail = 0, cyc = 0;

    always @(posedge clk) if (mem_req_o) mem_rdata_i <= mem[mem_addr_o[7:3]];

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int len_of(input int dlc, input bit fd);
        int tbl[7] = '{12, 16, 20, 24, 32, 48, 64};
        if (dlc <= 8) return dlc;
        return fd ? tbl[dlc-9] : 8;
    endfunction

    // Place one message at byte offset off and queue its expected beats.
    task automatic put_msg(input int off, input int tag, input bit ext, input bit rtr,
                           input logic [29:0] id, input logic [2:0] opts,
                           input int dlc, input logic [2:0] flags);
        int    len = len_of(dlc, opts[0]);
        int    nb = (len + 7) / 8;
        beat_t b;
        logic [31:0] w0;
        w0 = {ext, rtr, ext ? id : {id[11:0], 18'd0}};
        mem[off/8] = {dlc[3:0], opts, 22'd0, flags, w0};
        b.ext = ext; b.rtr = rtr; b.opts = opts; b.len = 7'(len);
        b.id  = ext ? id : {18'd0, id[11:0]};
        if (nb == 0) begin
            b.data = '0; b.last = 1'b1; expq.push_back(b);
        end
        for (int k = 0; k < nb; k++) begin
            int a = (off + 8 + 8*k) % RING;
            b.data = {32'hDA7A0000 | 32'(tag), 32'(k)};
            b.last = (k == nb - 1);
            mem[a/8] = b.data;
            expq.push_back(b);
        end
    endtask

    // Monitor: drive ready, compare accepted beats, check stall hold.
    logic  stalled = 1'b0;
    beat_t held;
    always @(negedge clk) begin
        beat_t g, e;
        cyc++;
        g = {msg_ext_o, msg_rtr_o, msg_id_o, msg_opts_o, msg_len_o, msg_data_o, msg_last_o};
        if (stalled && rst_n)
            chk(msg_valid_o && g == held, "R10 stall hold", g[63:0], held[63:0]);
        msg_ready_i = rst_n && (cyc % 3 != 1);
        stalled = msg_valid_o && !msg_ready_i;
        held = g;
        if (msg_valid_o && msg_ready_i) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R7 unexpected beat", g[63:0], 64'd0);
            end else begin
                e = expq.pop_front();
                chk({g.ext, g.rtr, g.id} == {e.ext, e.rtr, e.id}, "R2 header fields",
                    64'({g.ext, g.rtr, g.id}), 64'({e.ext, e.rtr, e.id}));
                chk({g.opts, g.len} == {e.opts, e.len}, "R3 length", 64'({g.opts, g.len}), 64'({e.opts, e.len}));
                chk(g.data == e.data && g.last == e.last, "R4 R5 payload beat", g.data, e.data);
            end
        end
    end

    // Run one batch and check its ending.
    task automatic batch(input int rp, input int wp, input int mx, input bit run,
                         input int exp_ptr, input int exp_left, input string req);
        int t = 0;
        @(negedge clk);
        rd_ptr_i = AW'(rp); wr_ptr_i = AW'(wp); max_msgs_i = CW'(mx); started_i = run;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && t < 3000) begin @(negedge clk); t++; end
        chk(done_o, {req, " done seen"}, 64'(done_o), 64'd1);
        chk(rd_ptr_we_o == run && rx_enable_o == run && not_started_o == !run,
            "R8 ending", 64'({rd_ptr_we_o, rx_enable_o, not_started_o}), 64'({run, run, !run}));
        if (run) chk(rd_ptr_wdata_o == AW'(exp_ptr), {req, " R6 new offset"}, 64'(rd_ptr_wdata_o), 64'(exp_ptr));
        chk(expq.size() == exp_left, {req, " R7 beats left"}, 64'(expq.size()), 64'(exp_left));
        @(negedge clk);
        chk(!done_o, "R8 done pulse", 64'(done_o), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < RING/8; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!msg_valid_o && !mem_req_o && !done_o, "R10 reset outputs",
            64'({msg_valid_o, mem_req_o, done_o}), 64'd0);
        chk({stat_overrun_o, stat_busoff_o, stat_errpass_o} == 3'b000, "R10 reset status",
            64'({stat_overrun_o, stat_busoff_o, stat_errpass_o}), 64'd0);

        // Classic: standard id, extended RTR zero length, DLC 12 clamped.
        put_msg(0, 1, 1'b0, 1'b0, 30'h0ABC, 3'b000, 3, 3'b000);
        put_msg(16, 2, 1'b1, 1'b1, 30'h1234567, 3'b000, 0, 3'b000);
        put_msg(32, 3, 1'b0, 1'b0, 30'h07F, 3'b110, 12, 3'b000);
        batch(0, 48, 10, 1'b1, 48, 0, "R2 R3 R4 classic");

        // FD 12 and 32 bytes, status flags on the last header.
        put_msg(48, 4, 1'b1, 1'b0, 30'h2AAAAAA, 3'b001, 9, 3'b000);
        put_msg(80, 5, 1'b0, 1'b0, 30'h555, 3'b011, 13, 3'b101);
        batch(48, 128, 10, 1'b1, 128, 0, "R3 R6 fd");
        chk({stat_overrun_o, stat_busoff_o, stat_errpass_o} == 3'b101, "R9 status",
            64'({stat_overrun_o, stat_busoff_o, stat_errpass_o}), 64'h5);

        // 64-byte FD frame near the ring end: payload and offset both wrap.
        put_msg(208, 6, 1'b1, 1'b0, 30'h3FFFFFFF, 3'b001, 15, 3'b010);
        batch(208, 32, 10, 1'b1, 32, 0, "R5 R6 wrap");
        chk({stat_overrun_o, stat_busoff_o, stat_errpass_o} == 3'b010, "R9 status update",
            64'({stat_overrun_o, stat_busoff_o, stat_errpass_o}), 64'h2);

        // Count limit, then the remainder.
        put_msg(32, 7, 1'b0, 1'b0, 30'h101, 3'b000, 8, 3'b000);
        put_msg(48, 8, 1'b0, 1'b1, 30'h202, 3'b000, 8, 3'b000);
        put_msg(64, 9, 1'b0, 1'b0, 30'h303, 3'b000, 8, 3'b000);
        batch(32, 80, 2, 1'b1, 64, 1, "R7 count limit");
        batch(64, 80, 5, 1'b1, 80, 0, "R7 slot limit");

        // Controller stopped: drains but no write-back.
        put_msg(80, 10, 1'b0, 1'b0, 30'h404, 3'b000, 1, 3'b000);
        batch(80, 96, 4, 1'b0, 0, 0, "R8 stopped");

        // Empty ring.
        batch(96, 96, 4, 1'b1, 96, 0, "R1 empty");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got %0d expected 0", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule